// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps calendar time (seconds, minutes, hours, day of week, day of month, month and a two-digit year) and moves it forward by one second whenever the one-second enable arrives while the oscillator-control field selects normal running. The count is kept in binary inside the block. Month lengths and leap years are handled, with the two-digit year read as a year from 2000 to 2099.

Each second runs as a staged update. First the count advances and the update-in-progress flag rises. Then, after a configurable number of 32.768 kHz ticks, the seven visible time registers are refreshed and the flag drops. The visible registers use BCD or plain binary, and the hour uses 12- or 24-hour form. At the same point the three alarm fields are compared with the new time, and the alarm and update-ended flags are raised.

While the hold input is high, software may rewrite the visible registers without the next update overwriting them. When hold is released, the count reloads from those registers.

Top module: `rtc_calendar`

## Requirements
- R1: The count advances on `sec_tick` only when `osc_ctrl` equals 3'b010. For any other value the tick is dropped: no count change, no update-in-progress, no refresh.
- R2: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the date. Day of week counts 0 to 6 and wraps to 0.
- R3: Day of month wraps to 1 after 31, or after 30 in months 4, 6, 9 and 11. February ends on day 29 when the year is a multiple of 4 and on day 28 otherwise. Month wraps 12 to 1 and carries. The year wraps 99 to 0.
- R4: With `bin_mode` low, every visible field is BCD: tens in bits 7:4 and units in bits 3:0. With `bin_mode` high, each field is the plain binary value. The same format is used when the registers are loaded.
- R5: With `hr24` high, the hour field holds 0 to 23. With `hr24` low, it holds the hour modulo 12, and bit 7 is set for hours 12 to 23. On load in 12-hour mode, a set bit 7 adds 12.
- R6: An accepted tick raises `uip` on the next cycle, unless hold is high. The visible registers are refreshed, and `uip` drops, on the UIP_TICKS-th cycle after that in which `tick_32k` is high.
- R7: While `hold` is high, `uip` stays low and the update does not refresh the visible registers. When `hold` falls, the count reloads from the visible registers.
- R8: A write (`wr_en`, with `wr_field` 0=sec, 1=min, 2=hour, 3=day of week, 4=day of month, 5=month, 6=year; 7 is ignored) stores `wr_data` in that visible register. If hold is low, the whole count reloads from the visible registers one cycle later.
- R9: When `alarm_ie` is high and each alarm field matches the new time, the update ORs 8'hA0 into `flags`. A field matches when its bits 7:6 are both 1, or when its value, decoded in the current format, equals the count. The hour is compared as 0 to 23.
- R10: When `update_ie` is high, every refresh ORs 8'h90 into `flags`.
- R11: `flag_clr` clears `flags` to 0. A flag set in the same cycle survives. `irq` equals `flags` bit 7.
- R12: After reset, the visible registers read sec 0, min 0, hour 0, day of week 0, day 1, month 1, year 0, and `flags` and `uip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_32k | input | 1 | 32.768 kHz tick enable, times the update window |
| sec_tick | input | 1 | One-second enable that starts an update |
| osc_ctrl | input | 3 | Oscillator control; 3'b010 allows counting |
| hold | input | 1 | Hold visible registers for software setting |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_ie | input | 1 | Alarm flag enable |
| update_ie | input | 1 | Update-ended flag enable |
| flag_clr | input | 1 | Clears the flag register |
| wr_en | input | 1 | Visible register write strobe |
| wr_field | input | 3 | Visible register select |
| wr_data | input | 8 | Write data |
| alm_sec | input | 8 | Seconds alarm field |
| alm_min | input | 8 | Minutes alarm field |
| alm_hour | input | 8 | Hours alarm field |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hours |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| year_o | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| flags | output | 8 | Event flags: bit 7 any, bit 5 alarm, bit 4 update ended |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle:
- a tick that the oscillator field rejects leaves the seconds count untouched;
- an accepted tick never leaves seconds out of range;
- with hold high, the visible registers change only by direct writes, and `uip` stays low;
- `uip` is never high without a pending update;
- the summary flag bit agrees with the alarm and update-ended bits.

Only the bench's scenarios can show the calendar itself: the month, leap-year and year rollovers, and the BCD, binary, 12-hour and 24-hour encodings. They also cover the reload when hold is released, the stretching of the update window when `tick_32k` pauses, and the alarm don't-care matching.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int UIP_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       sec_tick,
  input  logic [2:0] osc_ctrl,
  input  logic       hold,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       alarm_ie,
  input  logic       update_ie,
  input  logic       flag_clr,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip,
  output logic [7:0] flags,
  output logic       irq
);
  localparam int CW = $clog2(UIP_TICKS + 1);

  function automatic logic [6:0] dec(input logic [7:0] r, input logic b);
    logic [7:0] t;
    t = {4'd0, r[7:4]} * 8'd10 + {4'd0, r[3:0]};
    return b ? r[6:0] : t[6:0];
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic b);
    logic [6:0] t, o;
    t = v / 7'd10;
    o = v % 7'd10;
    return b ? {1'b0, v} : {t[3:0], o[3:0]};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [6:0] y);
    case (m)
      7'd2:                    return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                 return 7'd31;
    endcase
  endfunction

  function automatic logic amatch(input logic [7:0] a, input logic [6:0] v, input logic b);
    return (a[7:6] == 2'b11) || (dec(a, b) == v);
  endfunction

  logic [6:0] sec_c, min_c, hr_c, wday_c, mday_c, mon_c, year_c;
  logic [6:0] n_sec, n_min, n_hr, n_wday, n_mday, n_mon, n_year;
  logic [6:0][7:0] vis;
  logic [CW-1:0] cnt;
  logic hold_q, wr_ld_q, pend_q, uip_q;
  logic [7:0] flags_q;

  wire osc_ok = (osc_ctrl == 3'b010);
  wire ld     = (hold_q && !hold) || wr_ld_q;
  wire step   = sec_tick && osc_ok && !ld;
  wire fin    = pend_q && tick_32k && (cnt <= CW'(1)) && !step;
  wire hit    = amatch(alm_sec, sec_c, bin_mode) && amatch(alm_min, min_c, bin_mode)
              && amatch(alm_hour, hr_c, bin_mode);
  wire [7:0] fset = (fin && alarm_ie && hit ? 8'hA0 : 8'h00) | (fin && update_ie ? 8'h90 : 8'h00);

  wire [6:0] hr_ld  = dec({1'b0, vis[2][6:0]}, bin_mode) + ((!hr24 && vis[2][7]) ? 7'd12 : 7'd0);
  wire       pm     = (hr_c >= 7'd12);
  wire [7:0] hr_vis = hr24 ? enc(hr_c, bin_mode)
                           : ({pm, 7'd0} | enc(pm ? hr_c - 7'd12 : hr_c, bin_mode));

  assign sec_o  = vis[0];
  assign min_o  = vis[1];
  assign hour_o = vis[2];
  assign wday_o = vis[3];
  assign mday_o = vis[4];
  assign mon_o  = vis[5];
  assign year_o = vis[6];
  assign uip    = uip_q;
  assign flags  = flags_q;
  assign irq    = flags_q[7];

  always_comb begin
    n_sec = sec_c; n_min = min_c; n_hr = hr_c; n_wday = wday_c;
    n_mday = mday_c; n_mon = mon_c; n_year = year_c;
    if (sec_c >= 7'd59) begin
      n_sec = 7'd0;
      if (min_c >= 7'd59) begin
        n_min = 7'd0;
        if (hr_c >= 7'd23) begin
          n_hr   = 7'd0;
          n_wday = (wday_c >= 7'd6) ? 7'd0 : wday_c + 7'd1;
          if (mday_c >= month_len(mon_c, year_c)) begin
            n_mday = 7'd1;
            if (mon_c >= 7'd12) begin
              n_mon  = 7'd1;
              n_year = (year_c >= 7'd99) ? 7'd0 : year_c + 7'd1;
            end else n_mon = mon_c + 7'd1;
          end else n_mday = mday_c + 7'd1;
        end else n_hr = hr_c + 7'd1;
      end else n_min = min_c + 7'd1;
    end else n_sec = sec_c + 7'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_c <= '0; min_c <= '0; hr_c <= '0; wday_c <= '0;
      mday_c <= 7'd1; mon_c <= 7'd1; year_c <= '0;
      vis <= 56'h00_01_01_00_00_00_00;
      cnt <= '0;
      hold_q <= 1'b0; wr_ld_q <= 1'b0; pend_q <= 1'b0; uip_q <= 1'b0;
      flags_q <= '0;
    end else begin
      hold_q  <= hold;
      wr_ld_q <= wr_en && (wr_field != 3'd7) && !hold;
      if (ld) begin
        sec_c  <= dec(vis[0], bin_mode);
        min_c  <= dec(vis[1], bin_mode);
        hr_c   <= hr_ld;
        wday_c <= dec(vis[3], bin_mode);
        mday_c <= dec(vis[4], bin_mode);
        mon_c  <= dec(vis[5], bin_mode);
        year_c <= dec(vis[6], bin_mode);
      end else if (step) begin
        sec_c <= n_sec; min_c <= n_min; hr_c <= n_hr; wday_c <= n_wday;
        mday_c <= n_mday; mon_c <= n_mon; year_c <= n_year;
      end
      if (step) begin
        pend_q <= 1'b1;
        cnt    <= CW'(UIP_TICKS);
        uip_q  <= !hold;
      end else if (pend_q && tick_32k) begin
        if (fin) begin
          pend_q <= 1'b0;
          uip_q  <= 1'b0;
          if (!hold) begin
            vis[0] <= enc(sec_c, bin_mode);
            vis[1] <= enc(min_c, bin_mode);
            vis[2] <= hr_vis;
            vis[3] <= enc(wday_c, bin_mode);
            vis[4] <= enc(mday_c, bin_mode);
            vis[5] <= enc(mon_c, bin_mode);
            vis[6] <= enc(year_c, bin_mode);
          end
        end else cnt <= cnt - CW'(1);
      end
      if (hold) uip_q <= 1'b0;
      if (wr_en && wr_field != 3'd7) vis[wr_field] <= wr_data;
      flags_q <= (flag_clr ? 8'h00 : flags_q) | fset;
    end
  end

  a_r1_gated_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !osc_ok && !ld) |=> $stable(sec_c));
  a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sec_c < 7'd60));
  a_r7_hold_vis: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(vis));
  a_r7_hold_uip: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !uip_q);
  a_r6_uip_pending: assert property (@(posedge clk) disable iff (!rst_n)
    uip_q |-> pend_q);
  a_r11_irq_sum: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[7] == (flags_q[5] || flags_q[4]));
endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_32k = 1'b1, sec_tick = 1'b0;
  logic [2:0] osc_ctrl = 3'b010;
  logic hold = 1'b0, bin_mode = 1'b0, hr24 = 1'b1, alarm_ie = 1'b0, update_ie = 1'b0, flag_clr = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_field = 3'd0;
  logic [7:0] wr_data = 8'h00, alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, flags;
  logic uip, irq;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar #(.UIP_TICKS(8)) i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .sec_tick(sec_tick), .osc_ctrl(osc_ctrl),
    .hold(hold), .bin_mode(bin_mode), .hr24(hr24), .alarm_ie(alarm_ie), .update_ie(update_ie),
    .flag_clr(flag_clr), .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o),
    .mon_o(mon_o), .year_o(year_o), .uip(uip), .flags(flags), .irq(irq));

  // {bin_mode, hr24, start sec..year, expected sec..year}
  localparam logic [113:0] VEC [8] = '{
    {2'b01, 56'h59_59_23_06_31_12_99, 56'h00_00_00_00_01_01_00},
    {2'b01, 56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
    {2'b01, 56'h59_59_23_01_28_02_23, 56'h00_00_00_02_01_03_23},
    {2'b01, 56'h59_59_23_04_30_04_21, 56'h00_00_00_05_01_05_21},
    {2'b11, 56'h38_22_0C_01_0F_07_1E, 56'h39_22_0C_01_0F_07_1E},
    {2'b00, 56'h59_59_11_03_10_06_25, 56'h00_00_80_03_10_06_25},
    {2'b10, 56'h3B_3B_8B_05_1F_01_05, 56'h00_00_00_06_01_02_05},
    {2'b01, 56'h59_59_23_00_29_02_24, 56'h00_00_00_01_01_03_24}
  };

  function automatic logic [55:0] now_t();
    return {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] f, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_field = f; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load_time(input logic [55:0] t);
    @(negedge clk); hold = 1'b1;
    for (int k = 0; k < 7; k++) wr(3'(k), t[55 - 8*k -: 8]);
    @(negedge clk); hold = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset time", {8'h0, now_t()}, {8'h0, 56'h00_00_00_00_01_01_00});
    check("R12 reset flags/uip", {55'h0, flags, uip}, 64'h0);

    // R2 R3 R4 R5 table
    for (int i = 0; i < 8; i++) begin
      bin_mode = VEC[i][113]; hr24 = VEC[i][112];
      load_time(VEC[i][111:56]);
      do_tick();
      check($sformatf("R2/R3/R4/R5 vector %0d", i), {8'h0, now_t()}, {8'h0, VEC[i][55:0]});
    end

    // R6 update window, stretched by paused tick_32k
    bin_mode = 1'b0; hr24 = 1'b1;
    load_time(56'h10_00_00_00_01_01_00);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; tick_32k = 1'b0;
    repeat (30) @(negedge clk);
    check("R6 uip held while ticks paused", {63'h0, uip}, 64'h1);
    check("R6 no early refresh", {56'h0, sec_o}, 64'h10);
    tick_32k = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 uip mid window", {63'h0, uip}, 64'h1);
    repeat (10) @(negedge clk);
    check("R6 refresh and uip low", {55'h0, sec_o, uip}, {55'h0, 8'h11, 1'b0});

    // R7 hold
    load_time(56'h05_00_00_00_01_01_00);
    @(negedge clk); hold = 1'b1;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 no uip under hold", {63'h0, uip}, 64'h0);
    repeat (20) @(negedge clk);
    check("R7 no refresh under hold", {56'h0, sec_o}, 64'h05);
    hold = 1'b0;
    repeat (3) @(negedge clk);
    do_tick();
    check("R7 reload on release", {56'h0, sec_o}, 64'h06);

    // R8 direct write with hold low
    wr(3'd0, 8'h40);
    repeat (3) @(negedge clk);
    do_tick();
    check("R8 write reloads count", {56'h0, sec_o}, 64'h41);
    wr(3'd7, 8'h33);
    check("R8 field 7 ignored", {8'h0, now_t()}, {8'h0, 56'h41_00_00_00_01_01_00});

    // R1 oscillator gating
    load_time(56'h20_00_00_00_01_01_00);
    osc_ctrl = 3'b000; do_tick();
    check("R1 osc 000 no count", {56'h0, sec_o}, 64'h20);
    osc_ctrl = 3'b011; do_tick();
    check("R1 osc 011 no count", {56'h0, sec_o}, 64'h20);
    osc_ctrl = 3'b010; do_tick();
    check("R1 osc 010 counts", {56'h0, sec_o}, 64'h21);

    // R9 R10 R11 alarm and update flags
    load_time(56'h29_20_10_01_01_01_01);
    alm_sec = 8'h30; alm_min = 8'h20; alm_hour = 8'h10; alarm_ie = 1'b1;
    do_tick();
    check("R9 exact alarm", {55'h0, flags, irq}, {55'h0, 8'hA0, 1'b1});
    clr();
    check("R11 flag clear", {55'h0, flags, irq}, 64'h0);
    do_tick();
    check("R9 seconds mismatch", {56'h0, flags}, 64'h0);
    alm_sec = 8'hC0; alm_min = 8'hC0; alm_hour = 8'hC0;
    do_tick();
    check("R9 all don't-care", {56'h0, flags}, 64'hA0);
    clr();
    alm_min = 8'h20; alm_hour = 8'h11;
    do_tick();
    check("R9 hour mismatch", {56'h0, flags}, 64'h0);
    alarm_ie = 1'b0; alm_hour = 8'hC0;
    do_tick();
    check("R9 disabled alarm", {56'h0, flags}, 64'h0);
    update_ie = 1'b1;
    do_tick();
    check("R10 update ended", {55'h0, flags, irq}, {55'h0, 8'h90, 1'b1});
    clr();
    alarm_ie = 1'b1;
    do_tick();
    check("R9/R10 both flags", {56'h0, flags}, 64'hB0);
    clr();
    check("R11 clear both", {56'h0, flags}, 64'h0);

    finish_run();
  end
endmodule